// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the memory traffic of a subroutine call and of a subroutine return for a 32-bit processor core. The core decodes the instruction and hands over the current frame pointer, stack pointer, call address and call target. The sequencer then runs the stack accesses over a single-word memory port with a ready handshake. When it finishes, it returns the updated frame pointer, stack pointer and program counter together with a one-cycle completion pulse.

A call frame occupies three words below the incoming stack pointer. The top word is a reserved static-chain slot that is never written. Below it sits the return address, and below that the caller's frame pointer. After a call, the frame pointer and the stack pointer both address the saved frame pointer. A return starts from the frame pointer: it recovers the caller's frame pointer and the return address, then releases all three words.

Top module: `frame_seq`

## Requirements
- R1: After reset, and after a reset that arrives mid-sequence, the block is idle: mem_req, mem_we and done are low and new_pc, fp_out and sp_out are zero.
- R2: A call reserves the word at sp_in-4 as a static-chain slot and never writes it.
- R3: A call makes exactly two writes, in this order: the return address to sp_in-8, then fp_in to sp_in-12.
- R4: The pushed return address is call_pc+6 when via_reg is 0 (absolute-target call) and call_pc+2 when via_reg is 1 (register-target call).
- R5: When a call completes, fp_out and sp_out both equal sp_in-12 and new_pc equals target.
- R6: A return reads the saved frame pointer at fp_in, then the return address at fp_in+4. On completion, fp_out is the first word read, new_pc is the second, and sp_out is fp_in+12.
- R7: Each access holds mem_req, mem_we, mem_addr and mem_wdata steady until a cycle with mem_ready high, and the block advances only on such a cycle. Any number of wait cycles gives the same results.
- R8: done is high for exactly one cycle per sequence, no memory request is made in that cycle, and the results are valid from that cycle until the next sequence completes.
- R9: start_call and start_ret are ignored while a sequence is in progress, and a started sequence is never cut short. If both are raised together while idle, the call is taken.
- R10: mem_we is never high without mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_call | input | 1 | Begin a call sequence (sampled while idle) |
| start_ret | input | 1 | Begin a return sequence (sampled while idle) |
| via_reg | input | 1 | 1: register-target call (link = call_pc+2); 0: absolute call (link = call_pc+6) |
| call_pc | input | 32 | Address of the call instruction |
| target | input | 32 | Call destination |
| fp_in | input | 32 | Current frame pointer |
| sp_in | input | 32 | Current stack pointer |
| new_pc | output | 32 | Program counter after the sequence |
| fp_out | output | 32 | Frame pointer after the sequence |
| sp_out | output | 32 | Stack pointer after the sequence |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write strobe (1 = write) |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
The following properties are checked on every clock cycle:
- the bus handshake holds while mem_ready is low;
- mem_we never appears without mem_req;
- done lasts exactly one cycle and never overlaps a request;
- a sequence, once started, runs to completion without breaking off;
- at the end of a call, the frame pointer equals the stack pointer.

Only the bench scenarios can show the following:
- the frame layout, that is, which address holds which word;
- the write order;
- the link offset selection;
- that the static-chain slot stays untouched;
- the values recovered by a return;
- that starts during a busy sequence are ignored.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_PUSH_LINK,
    FS_PUSH_FP,
    FS_POP_FP,
    FS_POP_LINK,
    FS_FIN
  } fs_state_e;
endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_call,
  input  logic      start_ret,
  input  logic      mem_ready,
  output fs_state_e state,
  output logic      launch_call,
  output logic      launch_ret,
  output logic      step
);
  fs_state_e state_nxt;

  always_comb begin
    launch_call = (state == FS_IDLE) && start_call;
    launch_ret  = (state == FS_IDLE) && !start_call && start_ret;
    step        = (state != FS_IDLE) && (state != FS_FIN) && mem_ready;
  end

  always_comb begin
    state_nxt = state;
    case (state)
      FS_IDLE: begin
        if (launch_call)     state_nxt = FS_PUSH_LINK;
        else if (launch_ret) state_nxt = FS_POP_FP;
      end
      FS_PUSH_LINK: if (step) state_nxt = FS_PUSH_FP;
      FS_PUSH_FP:   if (step) state_nxt = FS_FIN;
      FS_POP_FP:    if (step) state_nxt = FS_POP_LINK;
      FS_POP_LINK:  if (step) state_nxt = FS_FIN;
      FS_FIN:       state_nxt = FS_IDLE;
      default:      state_nxt = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= FS_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/frame_regs.sv
module frame_regs
  import frame_seq_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned LINK_ABS  = 6,
  parameter int unsigned LINK_REG  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fs_state_e     state,
  input  logic          launch_call,
  input  logic          launch_ret,
  input  logic          step,
  input  logic          via_reg,
  input  logic [DW-1:0] call_pc,
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] fp_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] work_sp,
  output logic [DW-1:0] link_q,
  output logic [DW-1:0] fp_keep,
  output logic [DW-1:0] new_pc,
  output logic [DW-1:0] fp_out,
  output logic [DW-1:0] sp_out
);
  localparam int unsigned BYTES = DW / 8;
  localparam logic [DW-1:0] WSTEP = DW'(BYTES);
  localparam logic [DW-1:0] WSTEP2 = DW'(2 * BYTES);

  logic [DW-1:0] dest_q;

  logic          sp_en, link_en, fpk_en, dest_en, res_en;
  logic [DW-1:0] sp_nxt, link_nxt, fpk_nxt;
  logic [DW-1:0] pc_nxt, fpo_nxt, spo_nxt;

  always_comb begin
    sp_en    = launch_call || launch_ret ||
               (step && (state == FS_PUSH_LINK || state == FS_POP_FP));
    if (launch_call)          sp_nxt = sp_in - WSTEP2;
    else if (launch_ret)      sp_nxt = fp_in;
    else if (state == FS_POP_FP) sp_nxt = work_sp + WSTEP;
    else                      sp_nxt = work_sp - WSTEP;

    link_en  = launch_call;
    link_nxt = call_pc + (via_reg ? DW'(LINK_REG) : DW'(LINK_ABS));

    dest_en  = launch_call;

    fpk_en   = launch_call || (step && state == FS_POP_FP);
    fpk_nxt  = launch_call ? fp_in : mem_rdata;

    res_en   = step && (state == FS_PUSH_FP || state == FS_POP_LINK);
    if (state == FS_PUSH_FP) begin
      pc_nxt  = dest_q;
      fpo_nxt = work_sp;
      spo_nxt = work_sp;
    end else begin
      pc_nxt  = mem_rdata;
      fpo_nxt = fp_keep;
      spo_nxt = work_sp + WSTEP2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_sp <= '0;
      link_q  <= '0;
      fp_keep <= '0;
      dest_q  <= '0;
      new_pc  <= '0;
      fp_out  <= '0;
      sp_out  <= '0;
    end else begin
      if (sp_en)   work_sp <= sp_nxt;
      if (link_en) link_q  <= link_nxt;
      if (fpk_en)  fp_keep <= fpk_nxt;
      if (dest_en) dest_q  <= target;
      if (res_en) begin
        new_pc <= pc_nxt;
        fp_out <= fpo_nxt;
        sp_out <= spo_nxt;
      end
    end
  end
endmodule

// File: rtl/frame_bus.sv
module frame_bus
  import frame_seq_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  fs_state_e     state,
  input  logic [DW-1:0] work_sp,
  input  logic [DW-1:0] link_q,
  input  logic [DW-1:0] fp_keep,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      FS_PUSH_LINK: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = work_sp; mem_wdata = link_q;
      end
      FS_PUSH_FP: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = work_sp; mem_wdata = fp_keep;
      end
      FS_POP_FP, FS_POP_LINK: begin
        mem_req = 1'b1; mem_addr = work_sp;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned LINK_ABS = 6,
  parameter int unsigned LINK_REG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_call,
  input  logic          start_ret,
  input  logic          via_reg,
  input  logic [DW-1:0] call_pc,
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] fp_in,
  input  logic [DW-1:0] sp_in,
  output logic [DW-1:0] new_pc,
  output logic [DW-1:0] fp_out,
  output logic [DW-1:0] sp_out,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  fs_state_e     state;
  logic          launch_call, launch_ret, step;
  logic [DW-1:0] work_sp, link_q, fp_keep;

  frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_call(start_call), .start_ret(start_ret),
    .mem_ready(mem_ready), .state(state), .launch_call(launch_call),
    .launch_ret(launch_ret), .step(step)
  );

  frame_regs #(.DW(DW), .LINK_ABS(LINK_ABS), .LINK_REG(LINK_REG)) u_regs (
    .clk(clk), .rst_n(rst_n), .state(state), .launch_call(launch_call),
    .launch_ret(launch_ret), .step(step), .via_reg(via_reg), .call_pc(call_pc),
    .target(target), .fp_in(fp_in), .sp_in(sp_in), .mem_rdata(mem_rdata),
    .work_sp(work_sp), .link_q(link_q), .fp_keep(fp_keep),
    .new_pc(new_pc), .fp_out(fp_out), .sp_out(sp_out)
  );

  frame_bus #(.DW(DW)) u_bus (
    .state(state), .work_sp(work_sp), .link_q(link_q), .fp_keep(fp_keep),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign done = (state == FS_FIN);
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] fp_out,
  input logic [DW-1:0] sp_out
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  assert_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (mem_req || done));

  assert_we_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  assert_call_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready ##1 done |-> fp_out == sp_out);
endmodule

bind frame_seq frame_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .fp_out(fp_out), .sp_out(sp_out)
);

// File: tb/test_frame_seq.sv
module test_frame_seq;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_call = 1'b0, start_ret = 1'b0, via_reg = 1'b0;
  logic [31:0] call_pc = '0, target = '0, fp_in = '0, sp_in = '0;
  logic [31:0] new_pc, fp_out, sp_out, mem_addr, mem_wdata, mem_rdata;
  logic        done, mem_req, mem_we;
  logic        mem_ready = 1'b0;

  int tests = 0, fails = 0;
  int waits = 0, wcnt = 0;
  int nwr = 0;
  logic [31:0] wlog [4];
  logic [31:0] mem [256];

  always #10 clk = ~clk;

  frame_seq i_frame_seq (
    .clk(clk), .rst_n(rst_n), .start_call(start_call), .start_ret(start_ret),
    .via_reg(via_reg), .call_pc(call_pc), .target(target), .fp_in(fp_in),
    .sp_in(sp_in), .new_pc(new_pc), .fp_out(fp_out), .sp_out(sp_out), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      if (nwr < 4) wlog[nwr] <= mem_addr;
      nwr <= nwr + 1;
    end
  end

  always @(negedge clk) begin
    if (mem_ready || !mem_req) wcnt = 0;
    if (mem_req && wcnt >= waits) mem_ready = 1'b1;
    else begin
      mem_ready = 1'b0;
      if (mem_req) wcnt = wcnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    check(req, {31'd0, done}, 32'd1);
  endtask

  // {via_reg, waits, call_pc, target, fp, sp, expected link}
  localparam logic [223:0] VEC [5] = '{
    {32'd0, 32'd0, 32'h0000_1000, 32'h0000_2000, 32'h0000_03F0, 32'h0000_0200, 32'h0000_1006},
    {32'd1, 32'd0, 32'h0000_1000, 32'h0000_3000, 32'h0000_0300, 32'h0000_0180, 32'h0000_1002},
    {32'd0, 32'd2, 32'hFFFF_FFFC, 32'h0000_0040, 32'hAAAA_5555, 32'h0000_0100, 32'h0000_0002},
    {32'd1, 32'd3, 32'h1234_5678, 32'h8765_4320, 32'h0000_0000, 32'h0000_03F0, 32'h1234_567A},
    {32'd0, 32'd1, 32'h0000_0010, 32'h0000_0000, 32'h0000_0020, 32'h0000_0040, 32'h0000_0016}
  };

  task automatic do_call(input logic v, input logic [31:0] pc, tg, fp, sp);
    @(negedge clk);
    via_reg = v; call_pc = pc; target = tg; fp_in = fp; sp_in = sp; start_call = 1'b1;
    @(negedge clk);
    start_call = 1'b0;
  endtask

  task automatic do_ret(input logic [31:0] fp);
    @(negedge clk);
    fp_in = fp; sp_in = 32'h0000_0BAD; start_ret = 1'b1;
    @(negedge clk);
    start_ret = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = SENT;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 mem_we", {31'd0, mem_we}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 outputs", new_pc | fp_out | sp_out, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 5; k++) begin
      logic [223:0] e = VEC[k];
      logic [31:0] sp = e[63:32], fp = e[95:64], lnk = e[31:0];
      waits = int'(e[191:160]);
      nwr = 0;
      do_call(e[192], e[159:128], e[127:96], fp, sp);
      wait_done("R7 call completes");
      check("R5 new_pc", new_pc, e[127:96]);
      check("R5 fp_out", fp_out, sp - 32'd12);
      check("R5 sp_out", sp_out, sp - 32'd12);
      check("R4 link word", mem[(sp - 32'd8) >> 2], lnk);
      check("R3 saved fp", mem[(sp - 32'd12) >> 2], fp);
      check("R2 slot untouched", mem[(sp - 32'd4) >> 2], SENT);
      check("R3 write count", nwr, 32'd2);
      check("R3 first write addr", wlog[0], sp - 32'd8);
      check("R3 second write addr", wlog[1], sp - 32'd12);
      @(negedge clk);
      check("R8 done one cycle", {31'd0, done}, 32'd0);
      check("R8 result held", sp_out, sp - 32'd12);
      do_ret(sp - 32'd12);
      wait_done("R7 return completes");
      check("R6 new_pc", new_pc, lnk);
      check("R6 fp_out", fp_out, fp);
      check("R6 sp_out", sp_out, sp);
      mem[(sp - 32'd8) >> 2] = SENT;
      mem[(sp - 32'd12) >> 2] = SENT;
    end

    // R9: starts during a busy call are ignored
    waits = 2;
    do_call(1'b0, 32'h0000_0500, 32'h0000_0600, 32'h0000_0111, 32'h0000_0300);
    @(negedge clk);
    start_call = 1'b1; start_ret = 1'b1; sp_in = 32'h0000_0080; target = 32'h0000_0EEE;
    @(negedge clk);
    start_call = 1'b0; start_ret = 1'b0;
    wait_done("R9 busy call completes");
    check("R9 target kept", new_pc, 32'h0000_0600);
    check("R9 sp kept", sp_out, 32'h0000_02F4);
    @(negedge clk);
    @(negedge clk);
    check("R9 no restart", {31'd0, mem_req}, 32'd0);

    // R9: both starts together while idle -> call
    waits = 0;
    @(negedge clk);
    via_reg = 1'b1; call_pc = 32'h40; target = 32'h0000_0777; fp_in = 32'h5;
    sp_in = 32'h0000_0200; start_call = 1'b1; start_ret = 1'b1;
    @(negedge clk);
    start_call = 1'b0; start_ret = 1'b0;
    wait_done("R9 priority completes");
    check("R9 call wins pc", new_pc, 32'h0000_0777);
    check("R9 call wins link", mem[(32'h200 - 32'd8) >> 2], 32'h42);

    // R1: reset in the middle of a sequence
    waits = 3;
    do_call(1'b0, 32'h0, 32'h0000_0900, 32'h0, 32'h0000_0100);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset req", {31'd0, mem_req}, 32'd0);
    check("R1 mid reset done", {31'd0, done}, 32'd0);
    check("R1 mid reset outputs", new_pc | fp_out | sp_out, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle after reset", {30'd0, mem_req, mem_we}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule